// File: doc/BRIEF.md
# Supply Current-Limit Protection Monitor

This block protects the two switched supply groups of a device under test: the analog group and the digital group. An eight-channel power-supply ADC delivers its results one at a time. Each result arrives as a 12-bit value, a 3-bit channel number and a one-cycle valid strobe. Channels 0 to 3 carry voltage readings, and the monitor takes no action on them. Channels 4 to 7 carry supply currents:

| Channel | Current measured | Trip class |
|---------|------------------|------------|
| 4 | 3V3 analog front end | analog |
| 5 | 3V3 digital IO | digital |
| 6 | 1V8 analog | analog |
| 7 | 1V8 digital core | digital |

Each current channel has its own programmable 12-bit upper limit. When a current result is at or above its limit, the monitor clears supply enables in the same clock edge. An analog-class trip removes only the analog enable. A digital-class trip removes both enables.

Software reaches the block through a simple synchronous register port: a write strobe, a word address and write data. Read data is combinational from the address. The four limits are packed two per 32-bit word. A separate word turns each supply group on or off. Every read, at any address, returns the digital enable in bit 31 and the analog enable in bit 30. After a trip, the supplies stay off until software writes the enable word again.

Top module: `supply_trip_guard`

## Requirements
- R1: After reset both supply enables are 0, and all four limits are 0xFFF. Each limit word then reads 0x00FFFFFF, and a current sample of 0xFFE trips nothing.
- R2: Address 0 is the enable word. Bit 0 drives the analog enable and bit 1 drives the digital enable. Writing 1 turns the supply on and writing 0 turns it off, effective at the clock edge of the write. A read of address 0 returns the two enables in bits 1:0.
- R3: Address 1 holds the channel 4 limit in bits 11:0 and the channel 5 limit in bits 23:12. Address 2 holds the channel 6 limit in bits 11:0 and the channel 7 limit in bits 23:12. Bits 29:24 read 0, and writes to those bits are ignored.
- R4: Every read, at any address including the unmapped ones (3 to 7), returns the digital enable in bit 31 and the analog enable in bit 30. An unmapped address returns 0 in bits 29:0.
- R5: A current sample trips when its value is greater than or equal to its channel's limit. A value one below the limit does not trip.
- R6: A trip on channel 4 or channel 6 clears the analog enable and leaves the digital enable unchanged.
- R7: A trip on channel 5 or channel 7 clears both enables.
- R8: Samples on channels 0 to 3 never trip, whatever their value.
- R9: A trip overrides an enable write made in the same cycle. After a trip, the enables stay off until the enable word is written again. A re-enable made while the overcurrent persists is cleared by the next tripping sample.
- R10: A sample arriving in the same cycle as a write to its limit is compared against the old limit.
- R11: Sample inputs are ignored while the valid strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| smpValid | input | 1 | One-cycle strobe marking a new ADC result |
| smpChan | input | 3 | ADC channel number of the result |
| smpData | input | 12 | ADC result value |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr, combinational |
| anaSupplyEn | output | 1 | Analog supply group enable |
| digSupplyEn | output | 1 | Digital supply group enable |

## Verification
The bench places samples exactly at a limit and one count below it. A comparator using strict greater-than would miss the first case, and one off by one the other way would fire on the second. It trips each of the four current channels separately. A swapped class map would cut the wrong supply, or leave the digital supply on after a digital overcurrent. It also collides a trip with an enable write, and a sample with a write to that sample's own limit. Here a design with the wrong priority would re-enable a faulted supply, and one comparing against the new limit would trip early. Full-scale readings on the voltage channels, and strobes with valid held low, confirm that those inputs cannot drop a supply.

// File: rtl/trip_pkg.sv
package trip_pkg;

  // Register word addresses decoded by the control module
  localparam int ADDR_EN    = 0;
  localparam int ADDR_LIM_A = 1;
  localparam int ADDR_LIM_B = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrLimPair0;   // load limits of channels 4 and 5
    logic wrLimPair1;   // load limits of channels 6 and 7
  } ctlStrobe_t;

  // Trip strobes from datapath to control
  typedef struct packed {
    logic tripAna;      // analog-class current reached its limit
    logic tripDig;      // digital-class current reached its limit
  } tripStrobe_t;

endpackage

// File: rtl/trip_datapath.sv
module trip_datapath
  import trip_pkg::*;
#(
  parameter int SMP_W = 12,
  parameter int CH_W  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 smpValid,
  input  logic [CH_W-1:0]      smpChan,
  input  logic [SMP_W-1:0]     smpData,
  input  ctlStrobe_t           ctl,
  input  logic [2*SMP_W-1:0]   limWrData,
  output tripStrobe_t          trip,
  output logic [2*SMP_W-1:0]   limWord0,
  output logic [2*SMP_W-1:0]   limWord1
);

  localparam int NUM_CUR  = 4;
  localparam int CUR_BASE = 4;
  localparam int NUM_PAIR = NUM_CUR / 2;

  logic [NUM_CUR*SMP_W-1:0] limFlat;
  logic [NUM_PAIR-1:0]      anaHit;
  logic [NUM_PAIR-1:0]      digHit;

  // One limit register and comparator per current channel.
  // The lower lane of each pair is an analog current and the upper lane is a digital one.
  for (genvar gi = 0; gi < NUM_CUR; gi++) begin : g_cur
    localparam int PAIR = gi / 2;
    localparam int LANE = gi % 2;

    logic [SMP_W-1:0] limReg;
    logic             wrSel;
    logic             hit;

    assign wrSel = (PAIR == 0) ? ctl.wrLimPair0 : ctl.wrLimPair1;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)      limReg <= '1;
      else if (wrSel) limReg <= limWrData[LANE*SMP_W +: SMP_W];
    end

    assign hit = smpValid && (smpChan == CH_W'(CUR_BASE + gi)) && (smpData >= limReg);
    assign limFlat[gi*SMP_W +: SMP_W] = limReg;

    if (LANE == 0) begin : g_ana
      assign anaHit[PAIR] = hit;
    end else begin : g_dig
      assign digHit[PAIR] = hit;
    end
  end

  assign trip.tripAna = |anaHit;
  assign trip.tripDig = |digHit;

  assign limWord0 = limFlat[2*SMP_W-1:0];
  assign limWord1 = limFlat[4*SMP_W-1:2*SMP_W];

  // R8
  volt_chan_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (smpValid && (smpChan < CH_W'(CUR_BASE))) |-> (!trip.tripAna && !trip.tripDig));

  // R11
  no_valid_no_trip_chk: assert property (@(posedge clk) disable iff (!rstN)
    !smpValid |-> (!trip.tripAna && !trip.tripDig));

endmodule

// File: rtl/trip_control.sv
module trip_control
  import trip_pkg::*;
#(
  parameter int SMP_W  = 12,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [1:0]           enWrBits,
  input  tripStrobe_t          trip,
  input  logic [2*SMP_W-1:0]   limWord0,
  input  logic [2*SMP_W-1:0]   limWord1,
  output ctlStrobe_t           ctl,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 anaEn,
  output logic                 digEn
);

  logic enWr;
  logic anaNext;
  logic digNext;
  logic [DATA_W-1:0] rdBody;

  assign enWr           = regWr && (regAddr == ADDR_W'(ADDR_EN));
  assign ctl.wrLimPair0 = regWr && (regAddr == ADDR_W'(ADDR_LIM_A));
  assign ctl.wrLimPair1 = regWr && (regAddr == ADDR_W'(ADDR_LIM_B));

  // Software write first, then trips override it
  always_comb begin
    anaNext = anaEn;
    digNext = digEn;
    if (enWr) begin
      anaNext = enWrBits[0];
      digNext = enWrBits[1];
    end
    if (trip.tripAna) anaNext = 1'b0;
    if (trip.tripDig) begin
      anaNext = 1'b0;
      digNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      anaEn <= 1'b0;
      digEn <= 1'b0;
    end else begin
      anaEn <= anaNext;
      digEn <= digNext;
    end
  end

  // Read mux; the status bits overlay every address
  always_comb begin
    rdBody = '0;
    case (regAddr)
      ADDR_W'(ADDR_EN):    rdBody[1:0]         = {digEn, anaEn};
      ADDR_W'(ADDR_LIM_A): rdBody[2*SMP_W-1:0] = limWord0;
      ADDR_W'(ADDR_LIM_B): rdBody[2*SMP_W-1:0] = limWord1;
      default:             rdBody              = '0;
    endcase
    regRdData           = rdBody;
    regRdData[DATA_W-1] = digEn;
    regRdData[DATA_W-2] = anaEn;
  end

  // R7
  dig_trip_all_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    trip.tripDig |=> (!anaEn && !digEn));

  // R6
  ana_trip_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    trip.tripAna |=> !anaEn);

  // R6
  ana_trip_keeps_dig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trip.tripAna && !trip.tripDig && !enWr) |=> $stable(digEn));

  // R2
  en_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enWr && !trip.tripAna && !trip.tripDig) |=>
      (anaEn == $past(enWrBits[0]) && digEn == $past(enWrBits[1])));

  // R9
  ana_stays_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!anaEn && !enWr) |=> !anaEn);

  // R9
  dig_stays_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!digEn && !enWr) |=> !digEn);

endmodule

// File: rtl/supply_trip_guard.sv
module supply_trip_guard
  import trip_pkg::*;
#(
  parameter int SMP_W  = 12,
  parameter int CH_W   = 3,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              smpValid,
  input  logic [CH_W-1:0]   smpChan,
  input  logic [SMP_W-1:0]  smpData,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              anaSupplyEn,
  output logic              digSupplyEn
);

  ctlStrobe_t             ctl;
  tripStrobe_t            trip;
  logic [2*SMP_W-1:0]     limWord0;
  logic [2*SMP_W-1:0]     limWord1;
  logic                   unusedWrBits;

  assign unusedWrBits = ^regWrData[DATA_W-1:2*SMP_W];

  trip_datapath #(
    .SMP_W (SMP_W),
    .CH_W  (CH_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .smpValid  (smpValid),
    .smpChan   (smpChan),
    .smpData   (smpData),
    .ctl       (ctl),
    .limWrData (regWrData[2*SMP_W-1:0]),
    .trip      (trip),
    .limWord0  (limWord0),
    .limWord1  (limWord1)
  );

  trip_control #(
    .SMP_W  (SMP_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .enWrBits  (regWrData[1:0]),
    .trip      (trip),
    .limWord0  (limWord0),
    .limWord1  (limWord1),
    .ctl       (ctl),
    .regRdData (regRdData),
    .anaEn     (anaSupplyEn),
    .digEn     (digSupplyEn)
  );

endmodule

// File: tb/sim_supply_trip_guard.sv
module sim_supply_trip_guard;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        smpValid = 1'b0;
  logic [2:0]  smpChan = '0;
  logic [11:0] smpData = '0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        anaSupplyEn;
  logic        digSupplyEn;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  supply_trip_guard u0 (
    .clk         (clk),
    .rstN        (rstN),
    .smpValid    (smpValid),
    .smpChan     (smpChan),
    .smpData     (smpData),
    .regWr       (regWr),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .anaSupplyEn (anaSupplyEn),
    .digSupplyEn (digSupplyEn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkEn(input string tag, input logic expAna, input logic expDig);
    chk(tag, {30'd0, digSupplyEn, anaSupplyEn}, {30'd0, expDig, expAna});
  endtask

  task automatic wrReg(input logic [2:0] addr, input logic [31:0] data);
    @(negedge clk);
    regWr = 1'b1; regAddr = addr; regWrData = data;
    @(negedge clk);
    regWr = 1'b0; regWrData = '0;
  endtask

  task automatic sendSmp(input logic [2:0] ch, input logic [11:0] val);
    @(negedge clk);
    smpValid = 1'b1; smpChan = ch; smpData = val;
    @(negedge clk);
    smpValid = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] addr, output logic [31:0] data);
    @(negedge clk);
    regAddr = addr;
    #1;
    data = regRdData;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chkEn("R1 enables after reset", 1'b0, 1'b0);
    rdReg(3'd1, d); chk("R1 limit word A reset", d, 32'h00FF_FFFF);
    rdReg(3'd2, d); chk("R1 limit word B reset", d, 32'h00FF_FFFF);
    rdReg(3'd0, d); chk("R1 enable word reset", d, 32'h0000_0000);
    wrReg(3'd0, 32'h3);
    sendSmp(3'd4, 12'hFFE);
    sendSmp(3'd7, 12'hFFE);
    chkEn("R1 default limits do not trip below full scale", 1'b1, 1'b1);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wrReg(3'd0, 32'h3);
    chkEn("R2 both on", 1'b1, 1'b1);
    rdReg(3'd0, d); chk("R2 R4 read both on", d, 32'hC000_0003);
    wrReg(3'd0, 32'h1);
    chkEn("R2 analog only", 1'b1, 1'b0);
    rdReg(3'd0, d); chk("R4 read analog only", d, 32'h4000_0001);
    wrReg(3'd0, 32'h2);
    rdReg(3'd0, d); chk("R4 read digital only", d, 32'h8000_0002);
    wrReg(3'd0, 32'h0);
    chkEn("R2 both off", 1'b0, 1'b0);
  endtask

  task automatic t_limits();
    logic [31:0] d;
    wrReg(3'd0, 32'h3);
    wrReg(3'd1, 32'hFFAB_C123);
    rdReg(3'd1, d); chk("R3 limit word A packing", d, 32'hC0AB_C123);
    wrReg(3'd2, 32'h0045_6789);
    rdReg(3'd2, d); chk("R3 limit word B packing", d, 32'hC045_6789);
    rdReg(3'd5, d); chk("R4 unmapped address", d, 32'hC000_0000);
    rdReg(3'd3, d); chk("R4 unmapped address 3", d, 32'hC000_0000);
  endtask

  task automatic t_compare();
    wrReg(3'd1, 32'h0020_0100);
    wrReg(3'd2, 32'h0040_0300);
    wrReg(3'd0, 32'h3);
    sendSmp(3'd4, 12'h0FF);
    chkEn("R5 one below limit ch4", 1'b1, 1'b1);
    sendSmp(3'd4, 12'h100);
    chkEn("R5 R6 equal to limit ch4", 1'b0, 1'b1);
    wrReg(3'd0, 32'h3);
    sendSmp(3'd6, 12'h2FF);
    chkEn("R5 one below limit ch6", 1'b1, 1'b1);
    sendSmp(3'd6, 12'h3FF);
    chkEn("R6 ch6 trips analog only", 1'b0, 1'b1);
  endtask

  task automatic t_digTrip();
    wrReg(3'd0, 32'h3);
    sendSmp(3'd5, 12'h1FF);
    chkEn("R5 one below limit ch5", 1'b1, 1'b1);
    sendSmp(3'd5, 12'h200);
    chkEn("R7 ch5 trips all", 1'b0, 1'b0);
    wrReg(3'd0, 32'h3);
    sendSmp(3'd7, 12'h3FF);
    chkEn("R5 one below limit ch7", 1'b1, 1'b1);
    sendSmp(3'd7, 12'h401);
    chkEn("R7 ch7 trips all", 1'b0, 1'b0);
  endtask

  task automatic t_ignored();
    wrReg(3'd0, 32'h3);
    for (int c = 0; c < 4; c++) sendSmp(3'(c), 12'hFFF);
    chkEn("R8 voltage channels never trip", 1'b1, 1'b1);
    @(negedge clk);
    smpValid = 1'b0; smpChan = 3'd7; smpData = 12'hFFF;
    @(negedge clk);
    @(negedge clk);
    chkEn("R11 no valid no trip", 1'b1, 1'b1);
  endtask

  task automatic t_priority();
    @(negedge clk);
    regWr = 1'b1; regAddr = 3'd0; regWrData = 32'h3;
    smpValid = 1'b1; smpChan = 3'd7; smpData = 12'hFFF;
    @(negedge clk);
    regWr = 1'b0; smpValid = 1'b0;
    chkEn("R9 trip beats same-cycle write", 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chkEn("R9 stays off while idle", 1'b0, 1'b0);
    wrReg(3'd0, 32'h3);
    chkEn("R9 re-enable by write", 1'b1, 1'b1);
    sendSmp(3'd5, 12'h800);
    chkEn("R9 persistent overcurrent cuts again", 1'b0, 1'b0);
  endtask

  task automatic t_sameCycleLimit();
    wrReg(3'd0, 32'h3);
    @(negedge clk);
    regWr = 1'b1; regAddr = 3'd1; regWrData = 32'h0020_0050;
    smpValid = 1'b1; smpChan = 3'd4; smpData = 12'h080;
    @(negedge clk);
    regWr = 1'b0; smpValid = 1'b0;
    chkEn("R10 old limit used in collision cycle", 1'b1, 1'b1);
    sendSmp(3'd4, 12'h080);
    chkEn("R10 new limit applies afterwards", 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_limits();
    t_compare();
    t_digTrip();
    t_ignored();
    t_priority();
    t_sameCycleLimit();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule